// File: doc/BRIEF.md
# BCD Seven-Segment Latch Decoder

This block turns a 4-bit binary-coded decimal digit into seven active-high segment drives for a common-cathode display. It has a code hold stage, a segment pattern table and an output override stage. An active-low load enable chooses between two latch phases. In TRACK (enable low) the display follows the live input, and the holding register is reloaded on every clock edge. In HOLD (enable high) the display shows the code captured at the last edge on which the enable was still low, and further input changes are ignored. The phase is decoded from the enable level, so moving between phases takes no cycle. The ENTER_HOLD transition happens when the enable rises, and the RELEASE transition happens when it falls.

Two active-low overrides sit after the pattern table, and the override stage selects one of three display modes. LAMP (lamp test low) lights every segment and wins over everything. BLANK (lamp test high, blank low) darkens every segment. SHOW (both high) passes the decoded pattern through. The mode follows the override levels in the same cycle. Neither override reaches the holding register. Input codes above nine decode to a dark display. The digits 6 and 9 are drawn without their tails.

Top module: `seg7_latch_decoder`

## Requirements
- R1: While `latch_en_n` is low and both overrides are high, `seg_out` shows the pattern of the current `bcd_in` in the same cycle, with no clock delay.
- R2: While `latch_en_n` is high, `seg_out` shows the code sampled at the last rising clock edge on which `latch_en_n` was low, whatever `bcd_in` does.
- R3: When `lamp_test_n` is low, `seg_out` is 7'h7F, regardless of every other input.
- R4: When `lamp_test_n` is high and `blank_n` is low, `seg_out` is 7'h00.
- R5: The overrides never change the stored code. After an override is released during HOLD, the code captured before the override is shown again, including a code that was loaded while an override was active.
- R6: `seg_out` is packed as {g,f,e,d,c,b,a}, with segment a in bit 0. The digit patterns are: 0=7'h3F, 1=7'h06, 2=7'h5B, 3=7'h4F, 4=7'h66, 5=7'h6D, 6=7'h7C (no top tail), 7=7'h07, 8=7'h7F, 9=7'h67 (no bottom tail).
- R7: Codes 10 to 15 give `seg_out` = 7'h00 in SHOW mode.
- R8: A clock edge with `rst` high clears the stored code to 0. With `latch_en_n` high and the overrides released, the display then shows 7'h3F.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that loads the holding register |
| rst | input | 1 | Synchronous active-high reset of the stored code |
| latch_en_n | input | 1 | Active-low load enable: low = TRACK, high = HOLD |
| blank_n | input | 1 | Active-low blanking override |
| lamp_test_n | input | 1 | Active-low lamp test override |
| bcd_in | input | 4 | BCD digit, bit 0 least significant |
| seg_out | output | 7 | Segment drives {g,f,e,d,c,b,a}, active high |

## Verification
A capture edge and an override can fall in the same cycle. The enable rises while lamp test or blanking is low, so a code gets captured that the display never shows. The bench provokes this by loading a digit with the blanking override low and closing the latch in that state. It also does it with lamp test low while the input keeps changing. The result is judged after the overrides are released: the behavioural model expects the digit that was sampled at the last TRACK edge, not the one the display showed during the override.

// File: rtl/seg7_pkg.sv
package seg7_pkg;

    localparam int CODE_W     = 4;
    localparam int SEG_W      = 7;
    localparam int NUM_DIGITS = 10;

    localparam logic [SEG_W-1:0] SEG_ALL_ON  = {SEG_W{1'b1}};
    localparam logic [SEG_W-1:0] SEG_ALL_OFF = {SEG_W{1'b0}};

    typedef enum logic {
        LP_TRACK = 1'b0,
        LP_HOLD  = 1'b1
    } latch_phase_t;

    typedef enum logic [1:0] {
        DM_SHOW  = 2'd0,
        DM_BLANK = 2'd1,
        DM_LAMP  = 2'd2
    } disp_mode_t;

endpackage

// File: rtl/seg7_code_hold.sv
module seg7_code_hold
    import seg7_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              latch_en_n,
    input  logic [CODE_W-1:0] code_in,
    output logic [CODE_W-1:0] code_eff
);

    latch_phase_t      phase;
    logic [CODE_W-1:0] held_q;

    // Phase follows the enable level; TRACK reloads, HOLD keeps.
    always_comb begin
        phase = latch_en_n ? LP_HOLD : LP_TRACK;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            held_q <= '0;
        end else if (phase == LP_TRACK) begin
            held_q <= code_in;
        end
    end

    always_comb begin
        unique case (phase)
            LP_TRACK: code_eff = code_in;
            LP_HOLD:  code_eff = held_q;
            default:  code_eff = held_q;
        endcase
    end

endmodule

// File: rtl/seg7_pattern_rom.sv
module seg7_pattern_rom
    import seg7_pkg::*;
(
    input  logic [CODE_W-1:0] code,
    output logic [SEG_W-1:0]  pattern
);

    // Bit order {g,f,e,d,c,b,a}; codes past nine stay dark.
    always_comb begin
        case (code)
            CODE_W'(0): pattern = 7'h3F;
            CODE_W'(1): pattern = 7'h06;
            CODE_W'(2): pattern = 7'h5B;
            CODE_W'(3): pattern = 7'h4F;
            CODE_W'(4): pattern = 7'h66;
            CODE_W'(5): pattern = 7'h6D;
            CODE_W'(6): pattern = 7'h7C;
            CODE_W'(7): pattern = 7'h07;
            CODE_W'(8): pattern = 7'h7F;
            CODE_W'(9): pattern = 7'h67;
            default:    pattern = SEG_ALL_OFF;
        endcase
    end

endmodule

// File: rtl/seg7_override.sv
module seg7_override
    import seg7_pkg::*;
(
    input  logic             blank_n,
    input  logic             lamp_test_n,
    input  logic [SEG_W-1:0] pattern,
    output logic [SEG_W-1:0] seg
);

    disp_mode_t mode;

    // Lamp test outranks blanking.
    always_comb begin
        if (!lamp_test_n)  mode = DM_LAMP;
        else if (!blank_n) mode = DM_BLANK;
        else               mode = DM_SHOW;
    end

    always_comb begin
        unique case (mode)
            DM_LAMP:  seg = SEG_ALL_ON;
            DM_BLANK: seg = SEG_ALL_OFF;
            DM_SHOW:  seg = pattern;
            default:  seg = SEG_ALL_OFF;
        endcase
    end

endmodule

// File: rtl/seg7_latch_decoder.sv
module seg7_latch_decoder
    import seg7_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              latch_en_n,
    input  logic              blank_n,
    input  logic              lamp_test_n,
    input  logic [CODE_W-1:0] bcd_in,
    output logic [SEG_W-1:0]  seg_out
);

    logic [CODE_W-1:0] code_eff;
    logic [SEG_W-1:0]  pattern;

    seg7_code_hold u_hold (
        .clk        (clk),
        .rst        (rst),
        .latch_en_n (latch_en_n),
        .code_in    (bcd_in),
        .code_eff   (code_eff)
    );

    seg7_pattern_rom u_rom (
        .code    (code_eff),
        .pattern (pattern)
    );

    seg7_override u_ovr (
        .blank_n     (blank_n),
        .lamp_test_n (lamp_test_n),
        .pattern     (pattern),
        .seg         (seg_out)
    );

endmodule

// File: rtl/seg7_latch_decoder_chk.sv
module seg7_latch_decoder_chk
    import seg7_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              latch_en_n,
    input logic              blank_n,
    input logic              lamp_test_n,
    input logic [CODE_W-1:0] bcd_in,
    input logic [SEG_W-1:0]  seg_out
);

    logic started;
    always_ff @(posedge clk) begin
        if (rst) started <= 1'b1;
    end

    assert_lamp_all_on_R3: assert property (@(posedge clk) disable iff (rst)
        (!lamp_test_n) |-> (seg_out == 7'h7F));

    assert_blank_all_off_R4: assert property (@(posedge clk) disable iff (rst)
        (lamp_test_n && !blank_n) |-> (seg_out == 7'h00));

    assert_hold_stable_R2: assert property (@(posedge clk) disable iff (rst)
        (started && !$past(rst) && latch_en_n && $past(latch_en_n) &&
         lamp_test_n && blank_n && $past(lamp_test_n) && $past(blank_n))
        |-> $stable(seg_out));

    assert_non_decimal_dark_R7: assert property (@(posedge clk) disable iff (rst)
        (!latch_en_n && lamp_test_n && blank_n && (bcd_in > 4'd9))
        |-> (seg_out == 7'h00));

    assert_eight_live_R1: assert property (@(posedge clk) disable iff (rst)
        (!latch_en_n && lamp_test_n && blank_n && (bcd_in == 4'd8))
        |-> (seg_out == 7'h7F));

endmodule

bind seg7_latch_decoder seg7_latch_decoder_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .latch_en_n  (latch_en_n),
    .blank_n     (blank_n),
    .lamp_test_n (lamp_test_n),
    .bcd_in      (bcd_in),
    .seg_out     (seg_out)
);

// File: tb/sim_seg7_latch_decoder.sv
`timescale 1ns/1ps
module sim_seg7_latch_decoder;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       latch_en_n = 1'b1;
    logic       blank_n = 1'b1;
    logic       lamp_test_n = 1'b1;
    logic [3:0] bcd_in = 4'd0;
    logic [6:0] seg_out;

    int checks = 0;
    int fails  = 0;
    int model_code = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    seg7_latch_decoder u0 (
        .clk         (clk),
        .rst         (rst),
        .latch_en_n  (latch_en_n),
        .blank_n     (blank_n),
        .lamp_test_n (lamp_test_n),
        .bcd_in      (bcd_in),
        .seg_out     (seg_out)
    );

    // Behavioural reference: stored digit as a plain integer.
    always @(posedge clk) begin
        if (rst) model_code = 0;
        else if (!latch_en_n) model_code = int'(bcd_in);
    end

    function automatic logic [6:0] lit(input int d);
        string s;
        logic [6:0] v;
        case (d)
            0: s = "abcdef";
            1: s = "bc";
            2: s = "abdeg";
            3: s = "abcdg";
            4: s = "bcfg";
            5: s = "acdfg";
            6: s = "cdefg";
            7: s = "abc";
            8: s = "abcdefg";
            9: s = "abcfg";
            default: s = "";
        endcase
        v = '0;
        for (int i = 0; i < s.len(); i++) v[s[i] - "a"] = 1'b1;
        return v;
    endfunction

    function automatic logic [6:0] expected();
        if (!lamp_test_n) return 7'h7F;
        if (!blank_n) return 7'h00;
        if (latch_en_n) return lit(model_code);
        return lit(int'(bcd_in));
    endfunction

    task automatic check(input string tag);
        logic [6:0] e;
        e = expected();
        checks++;
        if (seg_out !== e) begin
            fails++;
            $display("FAIL %s: seg_out=%h expected=%h (le_n=%b bi_n=%b lt_n=%b in=%0d)",
                     tag, seg_out, e, latch_en_n, blank_n, lamp_test_n, bcd_in);
        end
    endtask

    // Drive after a rising edge, compare just after the falling edge.
    task automatic step(input logic le, input logic bi, input logic lt,
                        input logic [3:0] d, input string tag);
        @(posedge clk);
        #4;
        latch_en_n = le; blank_n = bi; lamp_test_n = lt; bcd_in = d;
        #10;
        check(tag);
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: run hung, actual=timeout expected=finish");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        // R8: reset clears the stored code; HOLD then shows zero.
        bcd_in = 4'd6;
        repeat (2) @(posedge clk);
        #4 rst = 1'b0;
        #10 check("R8");

        // R6 / R7: full code sweep in TRACK.
        for (int d = 0; d < 16; d++)
            step(1'b0, 1'b1, 1'b1, 4'(d), (d < 10) ? "R6" : "R7");

        // R1: transparent following.
        step(1'b0, 1'b1, 1'b1, 4'd3, "R1");
        step(1'b0, 1'b1, 1'b1, 4'd9, "R1");

        // R2: hold 5 while the input wanders.
        step(1'b0, 1'b1, 1'b1, 4'd5, "R1");
        step(1'b1, 1'b1, 1'b1, 4'd2, "R2");
        step(1'b1, 1'b1, 1'b1, 4'd9, "R2");
        step(1'b1, 1'b1, 1'b1, 4'd14, "R2");

        // R3 / R4 over a held code, then R5 release.
        step(1'b1, 1'b1, 1'b0, 4'd8, "R3");
        step(1'b1, 1'b0, 1'b1, 4'd8, "R4");
        step(1'b1, 1'b0, 1'b0, 4'd1, "R3");
        step(1'b1, 1'b1, 1'b1, 4'd8, "R5");

        // R5: load 7 under blanking, close the latch under blanking.
        step(1'b0, 1'b0, 1'b1, 4'd7, "R4");
        step(1'b1, 1'b0, 1'b1, 4'd1, "R4");
        step(1'b1, 1'b1, 1'b1, 4'd1, "R5");

        // R5: capture under lamp test with a changing input.
        step(1'b0, 1'b1, 1'b0, 4'd4, "R3");
        step(1'b0, 1'b1, 1'b0, 4'd6, "R3");
        step(1'b1, 1'b1, 1'b0, 4'd0, "R3");
        step(1'b1, 1'b1, 1'b1, 4'd0, "R5");

        // R8: reset while holding 9.
        step(1'b0, 1'b1, 1'b1, 4'd9, "R6");
        step(1'b1, 1'b1, 1'b1, 4'd9, "R2");
        @(posedge clk); #4 rst = 1'b1;
        @(posedge clk); #4 rst = 1'b0;
        #10 check("R8");

        // Mixed traffic compared against the model each cycle.
        for (int i = 0; i < 300; i++) begin
            logic le, bi, lt;
            logic [3:0] d;
            le = ($urandom_range(0, 2) != 0);
            bi = ($urandom_range(0, 5) != 0);
            lt = ($urandom_range(0, 7) != 0);
            d  = 4'($urandom_range(0, 15));
            step(le, bi, lt, d,
                 !lt ? "R3" : !bi ? "R4" : le ? "R2" : (d > 9) ? "R7" : "R1");
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule